// File: doc/BRIEF.md
# I2C Target Interface with Read Clock Stretching

This block is the target (responder) side of an I2C bus at one fixed 7-bit address. It watches the two bus lines, picks out START, repeated START and STOP conditions, and shifts in the address byte. It acknowledges its own address and then either takes in write bytes or serves read bytes. It never starts or ends a transfer by itself. Both lines are open-drain. The block drives only the pull-low enables `scl_oe` and `sda_oe`. A bus line reads high unless some device pulls it low.

Write bytes are handed to local logic on `rx_data` with a one-cycle `rx_valid` strobe. When the controller asks for a read byte, the block pulls SCL low and raises `rd_ready`. It keeps SCL low for as long as it takes, until local logic offers a byte with `rd_valid`. Clearing `enable` also lets SCL go. A one-cycle `byte_done` pulse marks the eighth bit of every byte in a transfer to this address.

Both bus inputs pass through two synchronising flip-flops. The system clock must be many times faster than SCL.

Top module: `i2c_slave_stretch`

## Requirements
- R1: While reset is asserted and right after it is released, `scl_oe`, `sda_oe`, `rd_ready`, `rx_valid` and `byte_done` are all 0.
- R2: After a START, the first byte is taken MSB first. Its upper seven bits are compared with `DEV_ADDR`, and its last bit selects the direction (1 = read). On a match the block pulls SDA low for the whole ninth clock (ACK).
- R3: In a write transfer, each data byte is received MSB first. After its eighth bit the byte appears on `rx_data` with a single-cycle `rx_valid`, and it is ACKed on the ninth clock.
- R4: If the address does not match, the block never pulls SDA low and gives no `rx_valid` and no `byte_done` until the next START or STOP.
- R5: After an ACKed read address, the block holds SCL low with `rd_ready` high and SDA released, for as long as `rd_valid` stays low.
- R6: A byte accepted on a cycle with `rd_valid` and `rd_ready` both high is driven onto SDA MSB first, and SCL is released at once.
- R7: If the controller ACKs a read byte (SDA low on the ninth clock), the block stretches again for the next byte. If it NACKs (SDA high), the block releases both lines and stops stretching until the next START.
- R8: One cycle after `enable` is low, `scl_oe` and `sda_oe` are both 0. While `enable` is low, bus activity has no effect.
- R9: `byte_done` pulses for one cycle after the eighth bit of every byte in a transfer to this address, including the address byte.
- R10: `sda_oe` changes only while SCL is low, so the block never produces a START or STOP condition.
- R11: A repeated START in the middle of a transfer restarts the address phase, so a write can be followed by a read without a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low releases the bus and idles |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (ACK or a 0 data bit) |
| rx_data | output | 8 | Last received write byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| rd_data | input | 8 | Read byte offered by local logic |
| rd_valid | input | 1 | `rd_data` is valid |
| rd_ready | output | 1 | Block is stretching and waiting for a read byte |
| byte_done | output | 1 | One-cycle pulse after the eighth bit of an addressed byte |

## Verification
The bench builds the block with `DEV_ADDR` = 7'h2D. A modelled controller drives the open-drain bus, and it picks between that address and random other addresses. This covers both the acknowledged path and the ignore-until-next-condition path. Read transfers have random lengths, so the bench exercises both the controller-ACK path (stretch again) and the final NACK path. Directed cases add a long stall, a disable in the middle of a stretch, and a repeated START that turns a write into a read.

// File: rtl/i2c_slave_stretch.sv
module i2c_slave_stretch #(
  parameter logic [6:0] DEV_ADDR = 7'h42
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic [7:0] rd_data,
  input  logic       rd_valid,
  output logic       rd_ready,
  output logic       byte_done
);

  typedef enum logic [2:0] {IDLE, ADDR, RECV, ACK, RWAIT, RSHF, RACK, IGNR} st_t;

  st_t        st;
  logic [2:0] scl_sh, sda_sh;
  logic [7:0] sh;
  logic [3:0] cnt;
  logic       rw;

  wire scl_s   = scl_sh[1];
  wire scl_q   = scl_sh[2];
  wire sda_s   = sda_sh[1];
  wire sda_q   = sda_sh[2];
  wire rise    = scl_s & ~scl_q;
  wire fall    = ~scl_s & scl_q;
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c  = scl_s & scl_q & ~sda_q & sda_s;
  wire [7:0] nxt = {sh[6:0], sda_s};

  assign scl_oe   = (st == RWAIT);
  assign rd_ready = (st == RWAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= 3'b111;
      sda_sh <= 3'b111;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_i};
      sda_sh <= {sda_sh[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      sh        <= '0;
      cnt       <= '0;
      rw        <= 1'b0;
      sda_oe    <= 1'b0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      rx_valid  <= 1'b0;
      byte_done <= 1'b0;
      if (!enable) begin
        st     <= IDLE;
        sda_oe <= 1'b0;
      end else if (start_c) begin
        st     <= ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ADDR, RECV: begin
            if (rise) begin
              sh  <= nxt;
              cnt <= cnt + 4'd1;
              if (cnt == 4'd7) begin
                if (st == ADDR) begin
                  if (nxt[7:1] == DEV_ADDR) begin
                    rw        <= nxt[0];
                    byte_done <= 1'b1;
                  end else begin
                    st <= IGNR;
                  end
                end else begin
                  rx_data   <= nxt;
                  rx_valid  <= 1'b1;
                  byte_done <= 1'b1;
                end
              end
            end else if (fall && cnt == 4'd8) begin
              st     <= ACK;
              sda_oe <= 1'b1;
            end
          end
          ACK: begin
            if (fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              st     <= rw ? RWAIT : RECV;
            end
          end
          RWAIT: begin
            if (rd_valid) begin
              sh     <= rd_data;
              sda_oe <= ~rd_data[7];
              cnt    <= '0;
              st     <= RSHF;
            end
          end
          RSHF: begin
            if (rise) begin
              cnt <= cnt + 4'd1;
              if (cnt == 4'd7) byte_done <= 1'b1;
            end else if (fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= RACK;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
              end
            end
          end
          RACK: begin
            if (rise && sda_s) st <= IGNR;
            else if (fall)     st <= RWAIT;
          end
          default: ;
        endcase
      end
    end
  end

  AST_SDA_CHG_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_s) || $past(start_c || stop_c || !enable)))
    else $error("sda_oe moved while SCL high"); // R10
  AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid) else $error("rx_valid longer than one cycle"); // R3
  AST_HOLD_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && !rd_valid && enable && !start_c && !stop_c) |=> scl_oe)
    else $error("stretch dropped without data"); // R5
  AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_oe && !sda_oe)) else $error("bus held while disabled"); // R8
  AST_NO_SDA_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> !sda_oe) else $error("SDA driven during stretch"); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done) else $error("byte_done longer than one cycle"); // R9

endmodule

// File: tb/tb_i2c_slave_stretch.sv
module tb_i2c_slave_stretch;
  localparam logic [6:0] DEV = 7'h2D;
  localparam int T = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic m_scl_low = 1'b0;
  logic m_sda_low = 1'b0;
  logic scl_bus, sda_bus;
  logic scl_oe, sda_oe, rx_valid, rd_ready, byte_done;
  logic [7:0] rx_data;
  logic [7:0] rd_data = 8'h00;
  logic rd_valid = 1'b0;

  always #10 clk = ~clk;

  assign scl_bus = !(m_scl_low || scl_oe);
  assign sda_bus = !(m_sda_low || sda_oe);

  i2c_slave_stretch #(.DEV_ADDR(DEV)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_data(rx_data), .rx_valid(rx_valid),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .byte_done(byte_done)
  );

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] rx_log [0:63];
  int rx_n = 0, bd_n = 0, oe_n = 0, viol = 0;
  logic prev_oe = 1'b0, prev_scl = 1'b1;

  always @(posedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        rx_log[rx_n % 64] <= rx_data;
        rx_n <= rx_n + 1;
      end
      if (byte_done) bd_n <= bd_n + 1;
      if (sda_oe) oe_n <= oe_n + 1;
      if (sda_oe !== prev_oe && prev_scl) viol <= viol + 1;
      prev_oe  <= sda_oe;
      prev_scl <= scl_bus;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_ack(input logic [6:0] a);
    return (a == DEV) ? 1'b0 : 1'b1;
  endfunction

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_high();
    m_scl_low = 1'b0;
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic mstart();
    m_sda_low = 1'b0; wt(T);
    scl_high();       wt(T);
    m_sda_low = 1'b1; wt(T);
    m_scl_low = 1'b1; wt(T);
  endtask

  task automatic mstop();
    m_sda_low = 1'b1; wt(T);
    scl_high();       wt(T);
    m_sda_low = 1'b0; wt(T);
  endtask

  task automatic wbit(input bit b);
    m_sda_low = !b; wt(T);
    scl_high();     wt(T);
    m_scl_low = 1'b1; wt(T);
  endtask

  task automatic rbit(output bit b);
    m_sda_low = 1'b0; wt(T);
    scl_high(); wt(T / 2);
    b = sda_bus; wt(T / 2);
    m_scl_low = 1'b1; wt(T);
  endtask

  task automatic mwbyte(input logic [7:0] d, output bit ack);
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(ack);
  endtask

  task automatic mrbyte(output logic [7:0] d, input bit nack);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      d[i] = b;
    end
    wbit(nack);
  endtask

  task automatic feed(input logic [7:0] d);
    while (!rd_ready) @(negedge clk);
    rd_data = d;
    rd_valid = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] b;
    int rx0, bd0, oe0;
    void'($urandom(32'h5EED));
    wt(4);
    chk(!scl_oe && !sda_oe && !rd_ready && !rx_valid && !byte_done, "R1 in reset",
        {scl_oe, sda_oe, rd_ready, rx_valid, byte_done}, 0);
    rst_n = 1'b1;
    enable = 1'b1;
    wt(4);
    chk(!scl_oe && !sda_oe && !rd_ready && !rx_valid && !byte_done, "R1 after reset",
        {scl_oe, sda_oe, rd_ready, rx_valid, byte_done}, 0);

    // R5 R6 R7: long stall, then a single read byte ending with a NACK
    bd0 = bd_n;
    mstart();
    mwbyte({DEV, 1'b1}, ack);
    chk(ack == 1'b0, "R2 read address ack", ack, 0);
    fork
      mrbyte(b, 1'b1);
      begin
        while (!rd_ready) @(negedge clk);
        wt(300);
        chk(scl_oe && !scl_bus && !sda_oe, "R5 stretch held", {scl_oe, scl_bus, sda_oe}, 3'b100);
        feed(8'hA5);
      end
    join
    chk(b == 8'hA5, "R6 read byte", b, 8'hA5);
    wt(40);
    chk(!rd_ready && !scl_oe && !sda_oe, "R7 release after NACK", {rd_ready, scl_oe, sda_oe}, 0);
    mstop();
    chk(bd_n - bd0 == 2, "R9 byte_done count", bd_n - bd0, 2);

    // R11: write then a repeated START into a read
    rx0 = rx_n;
    mstart();
    mwbyte({DEV, 1'b0}, ack);
    mwbyte(8'h3C, ack);
    chk(ack == 1'b0, "R3 write ack", ack, 0);
    mstart();
    mwbyte({DEV, 1'b1}, ack);
    chk(ack == 1'b0, "R11 restart address ack", ack, 0);
    fork
      mrbyte(b, 1'b1);
      feed(8'hC3);
    join
    chk(b == 8'hC3, "R11 read after restart", b, 8'hC3);
    mstop();
    chk(rx_n - rx0 == 1 && rx_log[rx0 % 64] == 8'h3C, "R3 write data", rx_log[rx0 % 64], 8'h3C);

    // R8: disable during a stretch
    rx0 = rx_n;
    mstart();
    mwbyte({DEV, 1'b1}, ack);
    fork
      mrbyte(b, 1'b1);
      begin
        while (!rd_ready) @(negedge clk);
        wt(50);
        enable = 1'b0;
        wt(2);
        chk(!scl_oe && !sda_oe && scl_bus, "R8 release on disable", {scl_oe, sda_oe, scl_bus}, 1);
      end
    join
    chk(b == 8'hFF, "R8 bus ignored while disabled", b, 8'hFF);
    mwbyte(8'h00, ack);
    chk(ack == 1'b1 && rx_n == rx0, "R8 no ack while disabled", ack, 1);
    mstop();
    enable = 1'b1;
    wt(5);

    // random transfers
    for (int i = 0; i < 16; i++) begin
      logic [6:0] a;
      bit rw;
      int n;
      logic [7:0] d [0:3];
      a  = ($urandom % 2) ? DEV : 7'($urandom % 128);
      if ($urandom % 2 == 0 && a == DEV) a = DEV;
      else if (a == DEV && i % 3 == 0) a = DEV ^ 7'h11;
      rw = 1'($urandom % 2);
      n  = 1 + ($urandom % 3);
      for (int j = 0; j < 4; j++) d[j] = 8'($urandom);
      rx0 = rx_n; bd0 = bd_n; oe0 = oe_n;
      mstart();
      mwbyte({a, rw}, ack);
      chk(ack == exp_ack(a), (a == DEV) ? "R2 address ack" : "R4 address nack", ack, exp_ack(a));
      if (a != DEV) begin
        for (int j = 0; j < n; j++) mwbyte(d[j], ack);
        chk(ack == 1'b1, "R4 data ignored", ack, 1);
        mstop();
        chk(rx_n == rx0 && bd_n == bd0 && oe_n == oe0, "R4 no activity",
            rx_n - rx0 + bd_n - bd0 + oe_n - oe0, 0);
      end else if (!rw) begin
        for (int j = 0; j < n; j++) begin
          mwbyte(d[j], ack);
          chk(ack == 1'b0, "R3 data ack", ack, 0);
        end
        mstop();
        chk(rx_n - rx0 == n, "R3 byte count", rx_n - rx0, n);
        for (int j = 0; j < n; j++)
          chk(rx_log[(rx0 + j) % 64] == d[j], "R3 data value", rx_log[(rx0 + j) % 64], d[j]);
        chk(bd_n - bd0 == n + 1, "R9 write byte_done", bd_n - bd0, n + 1);
      end else begin
        for (int j = 0; j < n; j++) begin
          fork
            mrbyte(b, j == n - 1);
            feed(d[j]);
          join
          chk(b == d[j], "R7 read sequence", b, d[j]);
        end
        mstop();
        chk(bd_n - bd0 == n + 1, "R9 read byte_done", bd_n - bd0, n + 1);
      end
    end

    wt(5);
    chk(viol == 0, "R10 SDA changed only with SCL low", viol, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule